// File: doc/BRIEF.md
# Sum-Product LDPC Check-Node Processing Element

This block is the check-node engine of a message-passing LDPC decoder. It takes in 48-bit packets from an on-chip network. Each packet carries two 16-bit sign-magnitude messages, one for each of two code blocks that are decoded side by side. The engine files each packet under a virtual check node, chosen by the packet's virtual ID. When the last expected message for that node has arrived, the engine stops taking input. It then sends one extrinsic reply packet per edge, back to the address the edge's message came from.

The nonlinear check function phi(x) = ln((e^x+1)/(e^x-1)) is held in a constant table of 256 entries. The table is indexed by the upper magnitude bits. For each code block the engine keeps the XOR of the incoming signs and the sum of phi over all edges. Each reply is then phi(sum minus the edge's own term), with the sign taken as the XOR of the other signs. A reply that would be zero or infinite is not sent as a full word. The word goes out as all zeros, and a per-word flag says which case applies, so the wires toggle less.

Both streams use valid/ready. A word moves on a cycle where valid and ready are both high. The output holds its packet and flags unchanged while it waits for ready. The input side is throttled by dropping `in_ready` for the whole emission burst.

Top module: `ldpc_cn_pe`

## Requirements
- R1: Packet layout, used on both sides: [47:43] physical address, [42:37] virtual ID, [36:33] edge count of the node (1..DEG_MAX), [32] mark bit. Block 1's word is in [31:16] and block 0's word is in [15:0]. A word has its sign in bit 15 and its magnitude in [14:0], with 10 fraction bits.
- R2: A packet is filed under slot (virtual ID mod NUM_VID). The node completes on the packet that brings that slot's received count equal to that packet's edge-count field. `out_valid` rises in the cycle after that packet is accepted.
- R3: `in_ready` is high exactly when no emission is in progress. After reset `in_ready`=1 and `out_valid`=0. `in_ready` and `out_valid` are never high together.
- R4: A completed node emits exactly edge-count packets, one per edge, in arrival order. Each carries the source address of that edge in [47:43], plus the virtual ID, edge count and mark bit of the packet that completed the node.
- R5: For each block, the output sign is the XOR of the signs of all the node's messages except the edge's own.
- R6: For each block, let T[k] = round(1024*phi((k+0.5)/8)) saturated to 32767. Let S be the sum of P(m) over the node's messages, where P(m) = T[|m|>>7]. Let D = S - P(own). The output magnitude is T[min(255, D>>7)].
- R7: A message whose magnitude is exactly zero contributes P = 32767, not a table entry.
- R8: When D = 0 the result is infinite. The word is sent as 0, and both `out_flag` and `out_inf` are set for that block.
- R9: When D is not 0 and the table result is 0, the word is sent as 0, `out_flag` is set and `out_inf` is cleared for that block.
- R10: The two blocks are computed independently. Flag bit b belongs to the word at [16b+15:16b].
- R11: While `out_valid` is high and `out_ready` is low, `out_data`, `out_flag` and `out_inf` hold. Each handshake moves to the next edge. After the last edge, `in_ready` returns high.
- R12: After a node completes, its slot's count, sign and sum start again from empty, ready for the next iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Input packet accepted when high with in_valid |
| in_data | input | 48 | Input packet |
| out_valid | output | 1 | Reply packet valid |
| out_ready | input | 1 | Downstream accepts reply |
| out_data | output | 48 | Reply packet |
| out_flag | output | 2 | Per-block flag: word replaced by zero |
| out_inf | output | 2 | Per-block flag: the replaced value is infinity |

## Verification
The bench builds the engine with NUM_VID=4 and DEG_MAX=6. With four slots, nodes can be interleaved, and a virtual ID above 3 folds onto a slot that is already in use. With six edges, the full-degree case and every degree down to one can be reached within a short run. Messages of exactly zero, very small and very large magnitude drive the zero and infinity paths. Random back-pressure on both sides exercises the stall and hold rules.

// File: rtl/cnpe_pkg.sv
package cnpe_pkg;
  localparam int WORD_W    = 16;
  localparam int MAG_W     = 15;
  localparam int FRAC_W    = 10;
  localparam int IDX_W     = 8;
  localparam int ROM_DEPTH = 1 << IDX_W;
  localparam int IDX_SHIFT = MAG_W - IDX_W;
  localparam int NBLK      = 2;
  localparam int PKT_W     = 48;
  localparam int PADDR_W   = 5;
  localparam int VID_W     = 6;
  localparam int MAXF_W    = 4;
  localparam int PADDR_LSB = 43;
  localparam int VID_LSB   = 37;
  localparam int MAXF_LSB  = 33;
  localparam int MARK_BIT  = 32;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [MAG_W-1:0]  mag_t;
  typedef logic [IDX_W-1:0]  idx_t;

  localparam mag_t MAG_SAT = '1;

  typedef enum logic {ST_COLLECT = 1'b0, ST_EMIT = 1'b1} pe_state_e;

  // phi(x) = ln((e^x+1)/(e^x-1)) at the centre of each index bucket, in fixed point
  function automatic mag_t phi_entry(input int k);
    real x, ex, v, scaled;
    x  = (real'(k) + 0.5) * real'(1 << IDX_SHIFT) / real'(1 << FRAC_W);
    ex = $exp(x);
    v  = $ln((ex + 1.0) / (ex - 1.0));
    scaled = v * real'(1 << FRAC_W) + 0.5;
    if (scaled >= real'(MAG_SAT)) return MAG_SAT;
    return mag_t'($rtoi(scaled));
  endfunction
endpackage

// File: rtl/cnpe_phi_rom.sv
module cnpe_phi_rom
  import cnpe_pkg::*;
(
  input  idx_t idx,
  output mag_t mag
);
  mag_t tbl [ROM_DEPTH];

  for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_ent
    localparam mag_t ENTRY = phi_entry(k);
    assign tbl[k] = ENTRY;
  end

  assign mag = tbl[idx];
endmodule

// File: rtl/cnpe_mag_phi.sv
module cnpe_mag_phi
  import cnpe_pkg::*;
(
  input  word_t msg,
  output mag_t  phi
);
  mag_t tbl_out;

  cnpe_phi_rom u_rom (
    .idx (msg[MAG_W-1 -: IDX_W]),
    .mag (tbl_out)
  );

  // R7: an exactly-zero magnitude carries no reliability, so phi is saturated
  assign phi = (msg[MAG_W-1:0] == '0) ? MAG_SAT : tbl_out;
endmodule

// File: rtl/cnpe_edge_calc.sv
module cnpe_edge_calc
  import cnpe_pkg::*;
#(
  parameter int SUM_W = 18
)(
  input  logic [SUM_W-1:0] sum_i,
  input  logic             xsign_i,
  input  word_t            edge_i,
  output word_t            word_o,
  output logic             flag_o,
  output logic             inf_o
);
  localparam int HI_W = SUM_W - IDX_SHIFT;

  mag_t             own_phi;
  mag_t             res_mag;
  logic [SUM_W-1:0] diff;
  logic [HI_W-1:0]  diff_hi;
  idx_t             res_idx;
  logic             sign;
  logic             is_zero;

  cnpe_mag_phi u_own (
    .msg (edge_i),
    .phi (own_phi)
  );

  // R6: remove the edge's own term, then map back through the table
  assign diff    = sum_i - SUM_W'(own_phi);
  assign diff_hi = diff[SUM_W-1:IDX_SHIFT];
  assign res_idx = (diff_hi > HI_W'(ROM_DEPTH - 1)) ? '1 : diff_hi[IDX_W-1:0];

  cnpe_phi_rom u_res (
    .idx (res_idx),
    .mag (res_mag)
  );

  // R5: extrinsic sign
  assign sign    = xsign_i ^ edge_i[WORD_W-1];
  // R8, R9
  assign inf_o   = (diff == '0);
  assign is_zero = !inf_o && (res_mag == '0);
  assign flag_o  = inf_o || is_zero;
  assign word_o  = flag_o ? '0 : {sign, res_mag};
endmodule

// File: rtl/cnpe_gather.sv
module cnpe_gather
  import cnpe_pkg::*;
#(
  parameter int NUM_VID = 4,
  parameter int DEG_MAX = 8,
  parameter int SLOT_W  = 2,
  parameter int CNT_W   = 4,
  parameter int EW      = 3,
  parameter int SUM_W   = 19
)(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SLOT_W-1:0]                wr_slot,
  input  logic [PADDR_W-1:0]               wr_paddr,
  input  logic [MAXF_W-1:0]                wr_max,
  input  logic [NBLK-1:0][WORD_W-1:0]      wr_words,
  input  logic [NBLK-1:0][MAG_W-1:0]       wr_phi,
  output logic                             wr_fire,
  input  logic                             clr_en,
  input  logic [SLOT_W-1:0]                clr_slot,
  input  logic [SLOT_W-1:0]                rd_slot,
  input  logic [EW-1:0]                    rd_idx,
  output logic [PADDR_W-1:0]               rd_paddr,
  output logic [NBLK-1:0][WORD_W-1:0]      rd_words,
  output logic [NBLK-1:0][SUM_W-1:0]       rd_sum,
  output logic [NBLK-1:0]                  rd_xsign
);
  logic [CNT_W-1:0]            cnt_q   [NUM_VID];
  logic [NBLK-1:0][SUM_W-1:0]  sum_q   [NUM_VID];
  logic [NBLK-1:0]             xs_q    [NUM_VID];
  logic [NBLK-1:0][WORD_W-1:0] words_q [NUM_VID][DEG_MAX];
  logic [PADDR_W-1:0]          paddr_q [NUM_VID][DEG_MAX];

  logic [CNT_W-1:0] wr_cnt;
  logic             wr_room;

  assign wr_cnt  = cnt_q[wr_slot];
  assign wr_room = int'(wr_cnt) < DEG_MAX;
  // R2: completion when the count including this packet matches its edge-count field
  assign wr_fire = (int'(wr_cnt) + 1) == int'(wr_max);

  for (genvar s = 0; s < NUM_VID; s++) begin : g_slot
    logic hit_wr, hit_clr;
    assign hit_wr  = wr_en  && (wr_slot  == SLOT_W'(s));
    assign hit_clr = clr_en && (clr_slot == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n || hit_clr) begin
        // R12: a fresh iteration starts from an empty slot
        cnt_q[s] <= '0;
        sum_q[s] <= '0;
        xs_q[s]  <= '0;
      end else if (hit_wr) begin
        cnt_q[s] <= cnt_q[s] + CNT_W'(1);
        for (int b = 0; b < NBLK; b++) begin
          sum_q[s][b] <= sum_q[s][b] + SUM_W'(wr_phi[b]);
          xs_q[s][b]  <= xs_q[s][b] ^ wr_words[b][WORD_W-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_room) begin
      words_q[wr_slot][wr_cnt[EW-1:0]] <= wr_words;
      paddr_q[wr_slot][wr_cnt[EW-1:0]] <= wr_paddr;
    end
  end

  assign rd_paddr = paddr_q[rd_slot][rd_idx];
  assign rd_words = words_q[rd_slot][rd_idx];
  assign rd_sum   = sum_q[rd_slot];
  assign rd_xsign = xs_q[rd_slot];
endmodule

// File: rtl/ldpc_cn_pe.sv
module ldpc_cn_pe
  import cnpe_pkg::*;
#(
  parameter int NUM_VID = 4,
  parameter int DEG_MAX = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [47:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [47:0] out_data,
  output logic [1:0]  out_flag,
  output logic [1:0]  out_inf
);
  localparam int SLOT_W = (NUM_VID > 1) ? $clog2(NUM_VID) : 1;
  localparam int CNT_W  = $clog2(DEG_MAX + 1);
  localparam int EW     = (DEG_MAX > 1) ? $clog2(DEG_MAX) : 1;
  localparam int SUM_W  = MAG_W + CNT_W;

  pe_state_e            state_q;
  logic [SLOT_W-1:0]    em_slot_q;
  logic [EW-1:0]        em_idx_q;
  logic [MAXF_W-1:0]    em_max_q;
  logic [VID_W-1:0]     em_vid_q;
  logic                 em_mark_q;

  logic                          in_fire, out_fire, em_last;
  logic                          wr_fire;
  logic [NBLK-1:0][WORD_W-1:0]   in_words;
  logic [NBLK-1:0][MAG_W-1:0]    in_phi;
  logic [VID_W-1:0]              in_vid;
  logic [MAXF_W-1:0]             in_max;
  logic [PADDR_W-1:0]            rd_paddr;
  logic [NBLK-1:0][WORD_W-1:0]   rd_words;
  logic [NBLK-1:0][SUM_W-1:0]    rd_sum;
  logic [NBLK-1:0]               rd_xsign;
  logic [NBLK-1:0][WORD_W-1:0]   res_words;

  // R1: header fields
  assign in_words = in_data[NBLK*WORD_W-1:0];
  assign in_vid   = in_data[VID_LSB +: VID_W];
  assign in_max   = in_data[MAXF_LSB +: MAXF_W];

  // R3: input is throttled for the whole emission burst
  assign in_ready  = (state_q == ST_COLLECT);
  assign out_valid = (state_q == ST_EMIT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign em_last   = (int'(em_idx_q) + 1) == int'(em_max_q);

  // R10: one phi lookup and one edge datapath per code block
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    cnpe_mag_phi u_in_phi (
      .msg (in_words[b]),
      .phi (in_phi[b])
    );

    cnpe_edge_calc #(.SUM_W(SUM_W)) u_edge (
      .sum_i   (rd_sum[b]),
      .xsign_i (rd_xsign[b]),
      .edge_i  (rd_words[b]),
      .word_o  (res_words[b]),
      .flag_o  (out_flag[b]),
      .inf_o   (out_inf[b])
    );
  end

  cnpe_gather #(
    .NUM_VID (NUM_VID),
    .DEG_MAX (DEG_MAX),
    .SLOT_W  (SLOT_W),
    .CNT_W   (CNT_W),
    .EW      (EW),
    .SUM_W   (SUM_W)
  ) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (in_fire),
    .wr_slot  (in_vid[SLOT_W-1:0]),
    .wr_paddr (in_data[PADDR_LSB +: PADDR_W]),
    .wr_max   (in_max),
    .wr_words (in_words),
    .wr_phi   (in_phi),
    .wr_fire  (wr_fire),
    .clr_en   (out_fire && em_last),
    .clr_slot (em_slot_q),
    .rd_slot  (em_slot_q),
    .rd_idx   (em_idx_q),
    .rd_paddr (rd_paddr),
    .rd_words (rd_words),
    .rd_sum   (rd_sum),
    .rd_xsign (rd_xsign)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_COLLECT;
      em_slot_q <= '0;
      em_idx_q  <= '0;
      em_max_q  <= '0;
      em_vid_q  <= '0;
      em_mark_q <= 1'b0;
    end else begin
      case (state_q)
        ST_COLLECT: begin
          if (in_fire && wr_fire) begin
            state_q   <= ST_EMIT;
            em_slot_q <= in_vid[SLOT_W-1:0];
            em_idx_q  <= '0;
            em_max_q  <= in_max;
            em_vid_q  <= in_vid;
            em_mark_q <= in_data[MARK_BIT];
          end
        end
        ST_EMIT: begin
          // R11: advance only on a handshake
          if (out_fire) begin
            if (em_last) state_q  <= ST_COLLECT;
            else         em_idx_q <= em_idx_q + EW'(1);
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  // R4: reply goes back to the edge's source address
  assign out_data = {rd_paddr, em_vid_q, em_max_q, em_mark_q, res_words};
endmodule

// File: rtl/ldpc_cn_pe_chk.sv
module ldpc_cn_pe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [47:0] out_data,
  input logic [1:0]  out_flag,
  input logic [1:0]  out_inf
);
  // R3
  io_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flag) && $stable(out_inf));

  // R8
  inf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_inf & ~out_flag) == 2'b00));

  // R9
  flag_word1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag[1] |-> out_data[31:16] == 16'h0000);

  // R9
  flag_word0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flag[0] |-> out_data[15:0] == 16'h0000);

  // R4
  burst_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || (out_data[42:32] == $past(out_data[42:32])));
endmodule

bind ldpc_cn_pe ldpc_cn_pe_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_flag  (out_flag),
  .out_inf   (out_inf)
);

// File: tb/ldpc_cn_pe_tb.sv
`timescale 1ns/1ps
module ldpc_cn_pe_tb;
  localparam int NV = 4;
  localparam int DM = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [47:0] in_data, out_data;
  logic [1:0]  out_flag, out_inf;

  always #5 clk = ~clk;

  ldpc_cn_pe #(.NUM_VID(NV), .DEG_MAX(DM)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_flag(out_flag), .out_inf(out_inf)
  );

  int n_tests = 0, n_fail = 0;
  int ptab [256];
  logic [47:0] stimq [$];
  int exp_total = 0, dut_emits = 0;

  // reference model state
  logic [47:0] mq [NV][$];
  int  mcnt [NV];
  bit  m_emit;
  int  em_slot, em_idx, em_max;
  logic [5:0] em_vid;
  logic em_mark;

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int phin(input logic [15:0] w);
    if (w[14:0] == 15'd0) return 32767;   // R7
    return ptab[w[14:7]];
  endfunction

  function automatic logic [15:0] mkword(input int mode);
    logic s;
    int m;
    s = 1'($urandom);
    case (mode)
      0: m = int'($urandom % 12288);
      1: m = 1 + int'($urandom % 100);
      2: m = 9216 + int'($urandom % 23551);
      3: m = 0;
      default: m = int'($urandom % 32768);
    endcase
    return {s, 15'(m)};
  endfunction

  task automatic gen_node(input int vid, input int deg, input int ma, input int mb, ref logic [47:0] q[$]);
    for (int j = 0; j < deg; j++) begin
      int a, b;
      a = (ma == 4) ? int'($urandom % 4) : ma;
      b = (mb == 4) ? int'($urandom % 4) : mb;
      q.push_back({5'($urandom), 6'(vid), 4'(deg), 1'($urandom), mkword(a), mkword(b)});
    end
    exp_total += deg;
  endtask

  task automatic add_node(input int vid, input int deg, input int ma, input int mb);
    logic [47:0] t [$];
    gen_node(vid, deg, ma, mb, t);
    foreach (t[i]) stimq.push_back(t[i]);
  endtask

  task automatic add_pair(input int va, input int da, input int vb, input int db);
    logic [47:0] ta [$];
    logic [47:0] tb [$];
    gen_node(va, da, 4, 4, ta);
    gen_node(vb, db, 4, 4, tb);
    while (ta.size() > 0 || tb.size() > 0) begin
      if (ta.size() > 0) stimq.push_back(ta.pop_front());
      if (tb.size() > 0) stimq.push_back(tb.pop_front());
    end
  endtask

  task automatic calc_exp(output logic [47:0] d, output logic [1:0] fl, output logic [1:0] nf);
    logic [47:0] ep;
    ep = mq[em_slot][em_idx];
    d = '0;
    d[47:32] = {ep[47:43], em_vid, 4'(em_max), em_mark};
    fl = 2'b00;
    nf = 2'b00;
    for (int b = 0; b < 2; b++) begin
      int s, dd, ix;
      bit xs;
      logic [15:0] we, w;
      s = 0;
      xs = 1'b0;
      foreach (mq[em_slot][j]) begin
        w = 16'(mq[em_slot][j] >> (16 * b));
        xs ^= w[15];
        s += phin(w);
      end
      we = 16'(ep >> (16 * b));
      dd = s - phin(we);
      if (dd == 0) begin
        fl[b] = 1'b1;
        nf[b] = 1'b1;
      end else begin
        ix = dd >> 7;
        if (ix > 255) ix = 255;
        if (ptab[ix] == 0) fl[b] = 1'b1;
        else d[16*b +: 16] = {xs ^ we[15], 15'(ptab[ix])};
      end
    end
  endtask

  initial begin : main
    logic [47:0] cur;
    bit cur_v;
    int cyc, tail;
    bit done;
    for (int k = 0; k < 256; k++) begin
      real x, e, v;
      x = (real'(k) + 0.5) / 8.0;
      e = $exp(x);
      v = $ln((e + 1.0) / (e - 1.0)) * 1024.0 + 0.5;
      ptab[k] = (v >= 32767.0) ? 32767 : $rtoi(v);
    end
    // stimulus
    add_node(0, 3, 0, 0);
    add_pair(1, 4, 2, 2);
    add_node(3, 1, 0, 0);          // R8 degree one: infinite for both blocks
    add_node(0, 4, 1, 1);          // R9 tiny messages give zero results
    add_node(1, 3, 2, 2);          // R8 large messages give infinity
    add_node(2, DM, 0, 0);         // full degree
    add_node(5, 3, 2, 1);          // R10 blocks differ; R2 vid 5 folds onto slot 1
    add_node(3, 3, 3, 0);          // R7 exact zero magnitudes in block 1
    for (int i = 0; i < 24; i++) begin  // R12 repeated iterations on reused slots
      if (i % 3 == 0) add_pair(i % 4, 1 + int'($urandom % DM), (i + 1) % 4, 1 + int'($urandom % DM));
      else add_node(i % 4 + 4 * int'($urandom % 2), 1 + int'($urandom % DM), 4, 4);
    end

    for (int s = 0; s < NV; s++) mcnt[s] = 0;
    m_emit = 1'b0; em_slot = 0; em_idx = 0; em_max = 0; em_vid = '0; em_mark = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R3 reset in_ready", 48'(in_ready), 48'd1);
    chk(out_valid === 1'b0, "R3 reset out_valid", 48'(out_valid), 48'd0);

    cur = '0; cur_v = 1'b0; cyc = 0; tail = 0; done = 1'b0;
    while (!done) begin
      bit in_f, out_f;
      // drive
      if (!cur_v && stimq.size() > 0 && ($urandom % 4 != 0)) begin
        cur = stimq.pop_front();
        cur_v = 1'b1;
      end
      in_valid  = cur_v;
      in_data   = cur_v ? cur : {16'($urandom), 32'($urandom)};
      out_ready = ($urandom % 3 != 0);
      in_f  = cur_v && !m_emit;
      out_f = m_emit && out_ready;
      if (out_valid && out_ready) dut_emits++;
      @(negedge clk);
      cyc++;
      // model update for the edge just passed
      if (in_f) begin
        int s;
        s = int'(cur[42:37]) % NV;
        mq[s].push_back(cur);
        mcnt[s]++;
        cur_v = 1'b0;
        if (mcnt[s] == int'(cur[36:33])) begin
          m_emit = 1'b1; em_slot = s; em_idx = 0;
          em_max = int'(cur[36:33]); em_vid = cur[42:37]; em_mark = cur[32];
        end
      end
      if (out_f) begin
        if (em_idx == em_max - 1) begin
          mq[em_slot].delete();
          mcnt[em_slot] = 0;
          m_emit = 1'b0;
        end else em_idx++;
      end
      // compare
      chk(in_ready === !m_emit, "R3 in_ready", 48'(in_ready), 48'(!m_emit));
      chk(out_valid === m_emit, "R2 R11 out_valid", 48'(out_valid), 48'(m_emit));
      if (m_emit && out_valid === 1'b1) begin
        logic [47:0] ed;
        logic [1:0] ef, ei;
        calc_exp(ed, ef, ei);
        chk(out_data[47:32] === ed[47:32], "R1 R4 header", 48'(out_data[47:32]), 48'(ed[47:32]));
        chk(out_data[31] === ed[31], "R5 sign blk1", 48'(out_data[31]), 48'(ed[31]));
        chk(out_data[15] === ed[15], "R5 R10 sign blk0", 48'(out_data[15]), 48'(ed[15]));
        chk(out_data[30:16] === ed[30:16], "R6 R7 mag blk1", 48'(out_data[30:16]), 48'(ed[30:16]));
        chk(out_data[14:0] === ed[14:0], "R6 R10 mag blk0", 48'(out_data[14:0]), 48'(ed[14:0]));
        chk(out_inf === ei, "R8 inf flags", 48'(out_inf), 48'(ei));
        chk(out_flag === ef, "R9 zero flags", 48'(out_flag), 48'(ef));
      end
      if (stimq.size() == 0 && !cur_v && !m_emit) tail++;
      if (tail > 5) done = 1'b1;
      if (cyc > 150000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
        done = 1'b1;
      end
    end
    chk(dut_emits == exp_total, "R4 R12 emit total", 48'(dut_emits), 48'(exp_total));
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule